// File: doc/BRIEF.md
# Handshaked PHY Configuration Port

This block lets software reach a small configuration register file inside a PHY through one 32-bit port word. Software does not address PHY registers directly. It writes the port word with a 6-bit PHY register index, a write byte and one of two request strobes. The block then carries out the access on the PHY side and raises an acknowledge flag in the same word, which software polls. When software sees the acknowledge, it clears the strobe. The acknowledge then drops, and the four-phase exchange is complete.

The PHY side is modelled here as 64 byte-wide registers. Each access is answered after a fixed, parameterised number of cycles. On a read, the fetched byte appears in a dedicated read-data field of the port word. In normal use the delay-line settings for each bus speed grade sit in the low PHY indices, 0x00 through 0x08 and 0x0B through 0x0D, and are loaded one write transfer at a time. A write transfer has three steps: load index and data with both strobes low, raise the write strobe with the same index and data, then drop the strobe once the acknowledge is seen.

Top module: `phy_port_bridge`

## Requirements
- R1: After reset the port word reads 0 and every PHY register holds 0.
- R2: Software-written fields read back in place: PHY index at bits 5:0, write byte at bits 15:8, write strobe at bit 24, read strobe at bit 25. The read byte is at bits 23:16 and the acknowledge is at bit 26.
- R3: Bits 31:27 and 7:6 always read 0. Software writes to those bits, to bit 26 and to bits 23:16 have no effect.
- R4: With the block idle, the acknowledge rises exactly ACK_DELAY+1 clock edges after the edge that loads a strobe. It then stays high for as long as a strobe is held.
- R5: The acknowledge is still high in the cycle after the edge that clears both strobes, and falls at the next edge.
- R6: A transfer with only the write strobe set stores the write byte into the indexed PHY register exactly once. A later read of that register returns the byte.
- R7: A transfer with the read strobe set places the indexed register's value in the read-data field no later than the edge that raises the acknowledge. The field then holds that value until another read transfer completes.
- R8: With both strobes set, the transfer is a read, and no PHY register changes.
- R9: Changes to the strobes, index or data while the acknowledge is high start no new access and modify no register. A fresh strobe is taken only after the acknowledge has fallen.
- R10: The index, data and direction of a transfer are captured one edge after the strobe is loaded. Rewriting them while the transfer is waiting for its acknowledge does not change which register is accessed or what is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write of the port word this cycle |
| sw_wdata | input | 32 | Value software writes to the port word |
| port_word | output | 32 | Current port word as software reads it |

## Verification
The bench goes after the handshake edges. Acknowledge latency is counted exactly. A design whose delay counter is off by one would raise the flag a cycle early or late. A design that drops the acknowledge on the clearing edge itself would fail the R5 check.

Three cases target accesses that must not happen:
- Swapping a held read strobe for a write strobe while acknowledged. A design that retriggers would corrupt the target register.
- Setting both strobes. A design that gives the write priority would overwrite the register.
- Rewriting the index during the wait. A design that does not capture the command would write the wrong register.

Reserved and read-only bits are hammered with ones. A design that stores them would show them in the read-back.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 8;

    // Field positions inside the port word
    localparam int unsigned ADDR_LSB  = 0;
    localparam int unsigned WDATA_LSB = 8;
    localparam int unsigned RDATA_LSB = 16;
    localparam int unsigned WR_BIT    = 24;
    localparam int unsigned RD_BIT    = 25;
    localparam int unsigned ACK_BIT   = 26;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } phy_cmd_t;
endpackage

// File: rtl/phy_port_rf.sv
module phy_port_rf #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/phy_port_hs.sv
module phy_port_hs
    import phy_port_pkg::*;
#(
    parameter int unsigned ACK_DELAY = 3,
    parameter int unsigned CNT_W     = $clog2(ACK_DELAY + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  phy_cmd_t req_cmd,
    output logic     ack,
    output logic     fire,
    output phy_cmd_t cur_cmd
);
    typedef struct packed {
        hs_state_e  st;
        logic [CNT_W-1:0] cnt;
        phy_cmd_t   cmd;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        fire = 1'b0;
        unique case (hs_q.st)
            HS_IDLE: begin
                if (req) begin
                    hs_d.st  = HS_WAIT;
                    hs_d.cnt = CNT_W'(ACK_DELAY - 1);
                    hs_d.cmd = req_cmd;
                end
            end
            HS_WAIT: begin
                if (hs_q.cnt == '0) begin
                    hs_d.st = HS_HOLD;
                    fire    = 1'b1;
                end else begin
                    hs_d.cnt = hs_q.cnt - 1'b1;
                end
            end
            HS_HOLD: begin
                if (!req) begin
                    hs_d.st = HS_IDLE;
                end
            end
            default: hs_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= '{st: HS_IDLE, cnt: '0, cmd: '0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign ack     = (hs_q.st == HS_HOLD);
    assign cur_cmd = hs_q.cmd;
endmodule

// File: rtl/phy_port_bridge.sv
module phy_port_bridge
    import phy_port_pkg::*;
#(
    parameter int unsigned ACK_DELAY = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_we,
    input  logic [31:0] sw_wdata,
    output logic [31:0] port_word
);
    localparam int unsigned CNT_W = $clog2(ACK_DELAY + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t    pt_d, pt_q;
    logic     hs_ack, hs_fire, hs_req;
    phy_cmd_t hs_cmd, req_cmd;
    logic     rf_we;
    logic [DATA_W-1:0] rf_rdata;

    // Both strobes together count as a read
    assign hs_req        = pt_q.rd | pt_q.wr;
    assign req_cmd.is_wr = pt_q.wr & ~pt_q.rd;
    assign req_cmd.addr  = pt_q.addr;
    assign req_cmd.wdata = pt_q.wdata;

    phy_port_hs #(
        .ACK_DELAY (ACK_DELAY),
        .CNT_W     (CNT_W)
    ) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (hs_req),
        .req_cmd (req_cmd),
        .ack     (hs_ack),
        .fire    (hs_fire),
        .cur_cmd (hs_cmd)
    );

    assign rf_we = hs_fire & hs_cmd.is_wr;

    phy_port_rf #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .addr  (hs_cmd.addr),
        .wdata (hs_cmd.wdata),
        .rdata (rf_rdata)
    );

    always_comb begin
        pt_d = pt_q;
        if (sw_we) begin
            pt_d.addr  = sw_wdata[ADDR_LSB +: ADDR_W];
            pt_d.wdata = sw_wdata[WDATA_LSB +: DATA_W];
            pt_d.rd    = sw_wdata[RD_BIT];
            pt_d.wr    = sw_wdata[WR_BIT];
        end
        if (hs_fire && !hs_cmd.is_wr) begin
            pt_d.rdata = rf_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    always_comb begin
        port_word = '0;
        port_word[ADDR_LSB  +: ADDR_W] = pt_q.addr;
        port_word[WDATA_LSB +: DATA_W] = pt_q.wdata;
        port_word[RDATA_LSB +: DATA_W] = pt_q.rdata;
        port_word[WR_BIT]  = pt_q.wr;
        port_word[RD_BIT]  = pt_q.rd;
        port_word[ACK_BIT] = hs_ack;
    end

    // Read-only and reserved bits of the software word are not stored
    logic unused_sw_bits;
    assign unused_sw_bits = ^{sw_wdata[31:27], sw_wdata[ACK_BIT],
                              sw_wdata[RDATA_LSB +: DATA_W],
                              sw_wdata[WDATA_LSB-1:ADDR_LSB+ADDR_W]};
endmodule

// File: rtl/phy_port_chk.sv
module phy_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] port_word,
    input logic        rf_we
);
    logic       ack, stb;
    logic [7:0] rbyte;

    assign ack   = port_word[26];
    assign stb   = port_word[25] | port_word[24];
    assign rbyte = port_word[23:16];

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && stb) |=> ack);                                   // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !stb) |=> !ack);                                 // R5
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);                                       // R6
    AST_RBYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(rbyte));                 // R7
    AST_NO_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !rf_we);                                         // R9
endmodule

bind phy_port_bridge phy_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_word (port_word),
    .rf_we     (rf_we)
);

// File: tb/tb_phy_port_bridge.sv
`timescale 1ns/1ps
module tb_phy_port_bridge;
    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] port_word;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic [7:0] model [64];
    logic [7:0] last_rd = 8'h00;

    phy_port_bridge #(.ACK_DELAY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .port_word(port_word)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input logic [5:0] a, input logic [7:0] d,
                                       input logic rd, input logic wr);
        return {5'b0, 1'b0, rd, wr, 8'h00, d, 2'b00, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic sw_write(input logic [31:0] w);
        @(negedge clk);
        sw_we = 1'b1;
        sw_wdata = w;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // Full transfer: setup, strobe, poll, release
    task automatic xfer(input logic [5:0] a, input logic [7:0] d,
                        input logic rd, input logic wr, input int hold);
        int cnt;
        sw_write(mk(a, d, 1'b0, 1'b0));
        chk("R2 field readback", port_word, mk(a, d, 1'b0, 1'b0) | {8'h0, last_rd, 16'h0});
        sw_write(mk(a, d, rd, wr));
        cnt = 0;
        while (!port_word[26] && cnt < 50) begin
            @(negedge clk);
            cnt++;
        end
        chk("R4 ack latency", cnt, DLY + 1);
        if (rd) begin
            last_rd = model[a];
            chk(wr ? "R8 both strobes read" : "R7 read byte", port_word[23:16], model[a]);
        end else begin
            model[a] = d;
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R4 ack held", port_word[26], 1'b1);
        end
        sw_write(mk(a, d, 1'b0, 1'b0));
        chk("R5 ack still high", port_word[26], 1'b1);
        @(negedge clk);
        chk("R5 ack fallen", port_word[26], 1'b0);
        chk("R7 read byte kept", port_word[23:16], last_rd);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 port word after reset", port_word, 32'h0);

        // R1: untouched registers read 0
        xfer(6'h3F, 8'h00, 1'b1, 1'b0, 0);
        xfer(6'h0D, 8'h00, 1'b1, 1'b0, 1);

        // R3: reserved and read-only bits are not stored
        sw_write(32'hFCFF_FFC5 & ~32'h0300_0000);
        chk("R3 reserved bits", port_word, mk(6'h05, 8'hFF, 1'b0, 1'b0) | {8'h0, last_rd, 16'h0});

        // R6: write delay settings then read back
        xfer(6'h00, 8'h11, 1'b0, 1'b1, 2);
        xfer(6'h08, 8'h5A, 1'b0, 1'b1, 0);
        xfer(6'h08, 8'h00, 1'b1, 1'b0, 0);
        xfer(6'h00, 8'h00, 1'b1, 1'b0, 0);

        // R8: both strobes must not write
        xfer(6'h0B, 8'hC3, 1'b0, 1'b1, 0);
        xfer(6'h0B, 8'hFF, 1'b1, 1'b1, 0);
        xfer(6'h0B, 8'h00, 1'b1, 1'b0, 0);

        // R9: strobe swap while acknowledged is ignored
        begin
            int cnt;
            sw_write(mk(6'h0C, 8'h00, 1'b1, 1'b0));
            cnt = 0;
            while (!port_word[26] && cnt < 50) begin @(negedge clk); cnt++; end
            last_rd = model[6'h0C];
            sw_write(mk(6'h0C, 8'h99, 1'b0, 1'b1));
            repeat (DLY + 3) @(negedge clk);
            chk("R9 ack stays high", port_word[26], 1'b1);
            chk("R9 read byte kept", port_word[23:16], last_rd);
            sw_write(mk(6'h0C, 8'h99, 1'b0, 1'b0));
            @(negedge clk);
            chk("R9 ack fallen", port_word[26], 1'b0);
            xfer(6'h0C, 8'h00, 1'b1, 1'b0, 0);
        end

        // R10: command captured before later rewrites
        begin
            int cnt;
            sw_write(mk(6'h02, 8'h77, 1'b0, 1'b0));
            sw_write(mk(6'h02, 8'h77, 1'b0, 1'b1));
            sw_write(mk(6'h03, 8'h44, 1'b0, 1'b1));
            cnt = 0;
            while (!port_word[26] && cnt < 50) begin @(negedge clk); cnt++; end
            chk("R10 ack arrives", port_word[26], 1'b1);
            model[6'h02] = 8'h77;
            sw_write(mk(6'h03, 8'h44, 1'b0, 1'b0));
            @(negedge clk);
            xfer(6'h02, 8'h00, 1'b1, 1'b0, 0);
            chk("R10 captured index", last_rd, 8'h77);
            xfer(6'h03, 8'h00, 1'b1, 1'b0, 0);
            chk("R10 other index untouched", last_rd, model[6'h03]);
        end

        // Random mix of reads, writes and both-strobe reads
        for (int n = 0; n < 150; n++) begin
            logic [5:0] a;
            logic [7:0] d;
            int op;
            a  = 6'($urandom_range(0, 63));
            d  = 8'($urandom_range(0, 255));
            op = $urandom_range(0, 3);
            case (op)
                0, 1: xfer(a, d, 1'b0, 1'b1, $urandom_range(0, 2));
                2:    xfer(a, d, 1'b1, 1'b0, $urandom_range(0, 2));
                default: xfer(a, d, 1'b1, 1'b1, 0);
            endcase
        end

        done = 1;
        summary();
    end
endmodule